// File: doc/BRIEF.md
# GPIO Bank Controller with Edge Interrupts

This block controls 32 general-purpose pins. The pins are split into a lower and an upper bank of 16 pins each, and both banks share one set of 32-bit registers on a simple word-wide register bus. Software sets the direction of each pin and drives outputs. It can do this through a plain data register, or through write-one set and clear registers, so it never has to read, modify and write a register. Software also reads pin levels after they pass a two-flop synchronizer.

Every pin has two interrupt enables, one for rising edges and one for falling edges. Each enable is changed only through its own write-one set register and write-one clear register. When an enabled edge is seen, a sticky status bit is set. Software clears status bits by writing a one to them. The lower and upper halves of the status register each drive one level interrupt line, and a per-bank enable bit gates that line.

The bus is a single-cycle select/write strobe with a byte address. Read data is combinational from the address. Byte address bits 1:0 are ignored.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every pin is an input (pad_oe_o all 0), the output latch is 0, both edge masks are 0, all status bits are 0, both bank enables are 0, and bank_irq_o is 0.
- R2: The direction word at 0x00 holds one bit per pin: 1 makes the pin an input and 0 makes it an output. pad_oe_o is high exactly for the output pins. The word reads back as written.
- R3: The output word at 0x04 can be written directly and reads back the output latch. The latch drives pad_out_o.
- R4: Writing a 1 to a bit at 0x08 sets that latch bit, and writing a 1 to a bit at 0x0C clears it. Zero bits change nothing. Both words read back the latch.
- R5: The input word at 0x10 returns the synchronized level of every pin, for inputs and outputs alike. A read in the cycle right after an output write still returns the old level. The new level is readable two clocks after the change.
- R6: The rising-edge mask is set by writing ones at 0x14 and cleared by writing ones at 0x18. The falling-edge mask is set at 0x1C and cleared at 0x20. Reading either word of a pair returns that mask. The two masks are independent of each other.
- R7: A status bit is set when its pin shows an edge of an enabled kind on the synchronized level. With both masks set, either edge sets the bit. An edge whose kind is not enabled leaves the bit unchanged. The bit is visible three clocks after the pad change.
- R8: The status word at 0x24 is sticky. Writing a 1 to a bit clears it, and zero bits have no effect.
- R9: If an edge sets a status bit on the same clock that a write-one clear targets it, the bit ends up set.
- R10: The bank enable word at 0x28 uses bit 0 for the lower bank and bit 1 for the upper bank. bank_irq_o[b] is the OR of status bits [16b+15:16b], ANDed with enable bit b.
- R11: Word addresses above 0x28 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i |
| pad_in_i | input | 32 | Pin levels from the pads |
| pad_out_o | output | 32 | Output values to the pads |
| pad_oe_o | output | 32 | Pad output enables, 1 = drive |
| bank_irq_o | output | 2 | Level interrupt per bank |

## Verification
The bench times a status clear to land on the same edge as an edge detection. A design that lets the clear win would lose that interrupt. It reads the input word one cycle after an output write. A design without the synchronizer would return the new level too early. It enables both edges on one pin and also toggles pins whose edge kind is disabled. This catches a shared mask, or detection on the raw pad rather than the synchronized level. Random bus traffic under a reference model checks that zero bits in set, clear and status writes are ignored, that each bank line follows only its own half of the status word, and that unmapped writes change nothing.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int unsigned BUS_AW = 6;

  typedef enum logic [3:0] {
    REG_DIR      = 4'd0,
    REG_OUT      = 4'd1,
    REG_SET      = 4'd2,
    REG_CLR      = 4'd3,
    REG_IN       = 4'd4,
    REG_RISE_SET = 4'd5,
    REG_RISE_CLR = 4'd6,
    REG_FALL_SET = 4'd7,
    REG_FALL_CLR = 4'd8,
    REG_STAT     = 4'd9,
    REG_BANK_EN  = 4'd10
  } reg_idx_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stage1_q, stage2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= '0;
      stage2_q <= '0;
      prev_q   <= '0;
    end else begin
      stage1_q <= pin_i;
      stage2_q <= stage1_q;
      prev_q   <= stage2_q;
    end
  end

  assign level_o = stage2_q;
  assign rise_o  = stage2_q & ~prev_q;
  assign fall_o  = ~stage2_q & prev_q;

  // edges are judged against last cycle's synchronized level
  assert_edge_prev_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((rise_o & $past(level_o)) == '0) && ((fall_o & ~$past(level_o)) == '0)));
endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  reg_idx_e     wr_idx_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] rise_en_o,
  output logic [W-1:0] fall_en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o     <= '1;
      out_o     <= '0;
      rise_en_o <= '0;
      fall_en_o <= '0;
    end else if (wr_en_i) begin
      unique case (wr_idx_i)
        REG_DIR:      dir_o     <= wdata_i;
        REG_OUT:      out_o     <= wdata_i;
        REG_SET:      out_o     <= out_o | wdata_i;
        REG_CLR:      out_o     <= out_o & ~wdata_i;
        REG_RISE_SET: rise_en_o <= rise_en_o | wdata_i;
        REG_RISE_CLR: rise_en_o <= rise_en_o & ~wdata_i;
        REG_FALL_SET: fall_en_o <= fall_en_o | wdata_i;
        REG_FALL_CLR: fall_en_o <= fall_en_o & ~wdata_i;
        default: ;
      endcase
    end
  end

  assert_set_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == REG_SET) |=> ((out_o & $past(wdata_i)) == $past(wdata_i)));

  assert_clr_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == REG_CLR) |=> ((out_o & $past(wdata_i)) == '0));

  assert_set_keeps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == REG_SET) |=> ((out_o & $past(out_o)) == $past(out_o)));

  assert_mask_indep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_idx_i == REG_RISE_SET || wr_idx_i == REG_RISE_CLR)) |=> $stable(fall_en_o));
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int unsigned W      = 32,
  parameter int unsigned BANK_W = 16,
  localparam int unsigned NB    = W / BANK_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  det_i,
  input  logic [W-1:0]  clr_i,
  input  logic          en_wr_i,
  input  logic [NB-1:0] en_wdata_i,
  output logic [W-1:0]  status_o,
  output logic [NB-1:0] bank_en_o,
  output logic [NB-1:0] irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o  <= '0;
      bank_en_o <= '0;
    end else begin
      // detection wins over a same-cycle clear
      status_o <= (status_o & ~clr_i) | det_i;
      if (en_wr_i) bank_en_o <= en_wdata_i;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign irq_o[b] = bank_en_o[b] & (|status_o[b*BANK_W +: BANK_W]);

    assert_irq_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[b] |-> bank_en_o[b]);
  end

  assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_o & $past(det_i)) == $past(det_i)));

  assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(status_o) & ~$past(clr_i) & ~status_o) == '0));

  assert_w1c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_o & $past(clr_i) & ~$past(det_i)) == '0));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned BANK_W   = 16,
  localparam int unsigned NB      = NUM_PINS / BANK_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_sel_i,
  input  logic                bus_we_i,
  input  logic [BUS_AW-1:0]   bus_addr_i,
  input  logic [NUM_PINS-1:0] bus_wdata_i,
  output logic [NUM_PINS-1:0] bus_rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NB-1:0]       bank_irq_o
);
  logic [3:0]          word_idx;
  logic                wr_en;
  reg_idx_e            idx;
  logic [NUM_PINS-1:0] dir, out_q, rise_en, fall_en;
  logic [NUM_PINS-1:0] level, rise, fall, det, clr, status;
  logic [NB-1:0]       bank_en;

  assign word_idx = bus_addr_i[BUS_AW-1:2];
  assign idx      = reg_idx_e'(word_idx);
  assign wr_en    = bus_sel_i & bus_we_i;

  gpio_ctrl_regs #(.W(NUM_PINS)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (idx),
    .wdata_i   (bus_wdata_i),
    .dir_o     (dir),
    .out_o     (out_q),
    .rise_en_o (rise_en),
    .fall_en_o (fall_en)
  );

  gpio_in_sync #(.W(NUM_PINS)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (pad_in_i),
    .level_o (level),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  assign det = (rise & rise_en) | (fall & fall_en);
  assign clr = (wr_en && word_idx == 4'(REG_STAT)) ? bus_wdata_i : '0;

  gpio_irq_status #(.W(NUM_PINS), .BANK_W(BANK_W)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .det_i      (det),
    .clr_i      (clr),
    .en_wr_i    (wr_en && word_idx == 4'(REG_BANK_EN)),
    .en_wdata_i (bus_wdata_i[NB-1:0]),
    .status_o   (status),
    .bank_en_o  (bank_en),
    .irq_o      (bank_irq_o)
  );

  assign pad_out_o = out_q;
  assign pad_oe_o  = ~dir;

  always_comb begin
    bus_rdata_o = '0;
    if (word_idx <= 4'(REG_BANK_EN)) begin
      unique case (idx)
        REG_DIR:                          bus_rdata_o = dir;
        REG_OUT, REG_SET, REG_CLR:        bus_rdata_o = out_q;
        REG_IN:                           bus_rdata_o = level;
        REG_RISE_SET, REG_RISE_CLR:       bus_rdata_o = rise_en;
        REG_FALL_SET, REG_FALL_CLR:       bus_rdata_o = fall_en;
        REG_STAT:                         bus_rdata_o = status;
        REG_BANK_EN:                      bus_rdata_o[NB-1:0] = bank_en;
        default: ;
      endcase
    end
  end

  assert_unmapped_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && word_idx > 4'(REG_BANK_EN)) |-> (bus_rdata_o == '0));

  assert_oe_dir_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && idx == REG_DIR) |=> (pad_oe_o == ~$past(bus_wdata_i)));
endmodule

// File: tb/gpio_bank_ctrl_tb.sv
module gpio_bank_ctrl_tb;
  localparam int unsigned CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, pad_in, pad_out, pad_oe;
  logic [1:0]  irq;
  logic [31:0] ext = '0;

  int unsigned checks = 0, errors = 0;

  logic [31:0] m_dir = '1, m_out = '0, m_rise = '0, m_fall = '0, m_stat = '0;
  logic [1:0]  m_en = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  gpio_bank_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe), .bank_irq_o(irq)
  );

  function automatic logic [31:0] lvl();
    return (m_dir & ext) | (~m_dir & m_out);
  endfunction

  function automatic logic [1:0] exp_irq();
    return {m_en[1] & (|m_stat[31:16]), m_en[0] & (|m_stat[15:0])};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic add_edges(input logic [31:0] o, input logic [31:0] n);
    m_stat |= (n & ~o & m_rise) | (o & ~n & m_fall);
  endtask

  // register write with model update; edges from the resulting level change
  task automatic op(input int unsigned w, input logic [31:0] d);
    logic [31:0] o;
    o = lvl();
    case (w)
      0:  m_dir = d;
      1:  m_out = d;
      2:  m_out |= d;
      3:  m_out &= ~d;
      5:  m_rise |= d;
      6:  m_rise &= ~d;
      7:  m_fall |= d;
      8:  m_fall &= ~d;
      9:  m_stat &= ~d;
      10: m_en = d[1:0];
      default: ;
    endcase
    bus_wr(6'(w*4), d);
    add_edges(o, lvl());
  endtask

  task automatic pins(input logic [31:0] d);
    logic [31:0] o;
    o = lvl();
    @(negedge clk);
    ext = d;
    add_edges(o, lvl());
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [31:0] r;
    chk({tag, " R2 oe"}, pad_oe, ~m_dir);
    chk({tag, " R3 out"}, pad_out, m_out);
    bus_rd(6'h00, r); chk({tag, " R2 dir"}, r, m_dir);
    bus_rd(6'h08, r); chk({tag, " R4 set rd"}, r, m_out);
    bus_rd(6'h10, r); chk({tag, " R5 in"}, r, lvl());
    bus_rd(6'h18, r); chk({tag, " R6 rise"}, r, m_rise);
    bus_rd(6'h1C, r); chk({tag, " R6 fall"}, r, m_fall);
    bus_rd(6'h24, r); chk({tag, " R7 R8 stat"}, r, m_stat);
    bus_rd(6'h28, r); chk({tag, " R10 en"}, r, {30'd0, m_en});
    chk({tag, " R10 irq"}, {30'd0, irq}, {30'd0, exp_irq()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r, o;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1 reset state
    chk("R1 oe", pad_oe, 32'h0);
    chk("R1 out", pad_out, 32'h0);
    chk("R1 irq", {30'd0, irq}, 32'h0);
    check_all("R1");

    // R5 stale read right after output change, then new level
    op(0, 32'hFFFF_FFFE);
    settle();
    op(2, 32'h1);
    bus_rd(6'h10, r); chk("R5 stale", r & 32'h1, 32'h0);
    repeat (2) @(negedge clk);
    bus_rd(6'h10, r); chk("R5 new", r & 32'h1, 32'h1);
    op(3, 32'h1); settle();
    chk("R4 clr", pad_out & 32'h1, 32'h0);

    // R4 zero bits ignored
    op(1, 32'h00F0_0F00); settle();
    op(2, 32'h0000_0001); op(3, 32'h0000_0100); settle();
    chk("R4 mask", pad_out, 32'h00F0_0E01);
    op(0, 32'hFFFF_FFFF); settle();

    // R7 both edges on one pin, disabled edge kind on another
    op(5, 32'h0000_0010); op(7, 32'h0000_0010); op(5, 32'h0001_0000);
    pins(32'h0001_0010); settle();
    bus_rd(6'h24, r); chk("R7 rise both", r, 32'h0001_0010);
    op(9, 32'hFFFF_FFFF); settle();
    pins(32'h0); settle();
    bus_rd(6'h24, r); chk("R7 fall enabled only", r, 32'h0000_0010);

    // R10 gating per bank
    op(10, 32'h0); settle();
    chk("R10 off", {30'd0, irq}, 32'h0);
    op(10, 32'h2); settle();
    chk("R10 other bank", {30'd0, irq}, 32'h0);
    op(10, 32'h1); settle();
    chk("R10 on", {30'd0, irq}, 32'h1);
    op(9, 32'h0000_0010); settle();
    chk("R8 cleared irq", {30'd0, irq}, 32'h0);

    // R9 edge and clear on the same clock
    op(7, 32'h8);
    pins(32'h8); settle();
    op(9, 32'hFFFF_FFFF); settle();
    pins(32'h8); settle();
    pins(32'h0); settle();
    bus_rd(6'h24, r); chk("R9 setup", r, 32'h8);
    pins(32'h8); settle();
    o = lvl();
    @(negedge clk); ext = 32'h0;
    @(posedge clk); @(posedge clk);
    bus_wr(6'h24, 32'h8);
    m_stat &= ~32'h8;
    add_edges(o, lvl());
    bus_rd(6'h24, r); chk("R9 set wins", r & 32'h8, 32'h8);
    op(9, 32'h8); settle();
    bus_rd(6'h24, r); chk("R8 w1c", r & 32'h8, 32'h0);

    // R11 unmapped words
    bus_wr(6'h2C, 32'hFFFF_FFFF);
    bus_wr(6'h3C, 32'hFFFF_FFFF);
    bus_rd(6'h2C, r); chk("R11 rd 2c", r, 32'h0);
    bus_rd(6'h38, r); chk("R11 rd 38", r, 32'h0);
    settle();
    check_all("R11");

    // random traffic against the model
    for (int i = 0; i < 300; i++) begin
      int unsigned w;
      logic [31:0] d;
      w = $urandom_range(0, 11);
      d = $urandom();
      if (w == 4 || w == 11) pins(d);
      else op(w, d);
      settle();
      check_all("rand");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule